// File: doc/BRIEF.md
# External Interrupt Flag Aggregator

This block watches sixteen external interrupt request pins and two non-maskable request pins, one for each of two processor cores. Each pin is brought into the clock domain through a two-flop synchronizer, and a rising edge after synchronization sets a sticky status flag. Software sees the flags in a 32-bit status register and clears any flag by writing a one to its bit. Writing a zero to a flag's bit leaves it unchanged.

A 32-bit enable register gates how the external flags reach the interrupt controller. External sources 0 to 3 each drive their own request line. Sources 4 to 15 are merged into a single shared line. The enable bits only gate this path and never stop a flag from being set. The two non-maskable flags go straight to their cores' request outputs with no gating.

The register port is a plain single-beat interface with no handshake. A read returns data in the same cycle from the address presented. A write is applied at the next rising clock edge.

Top module: `ext_irq_aggregator`

## Requirements
- R1: After reset, every status flag, every enable bit, `irq_o` and `nmi_req_o` are 0.
- R2: A rising edge on `ext_req_i[n]` sets external flag n at the third rising clock edge after the input changes, counting the first edge that samples it as edge 1. At edges 1 and 2 the flag is still 0.
- R3: A rising edge on `nmi_i[k]` sets non-maskable flag k with the same latency as R2. `nmi_req_o[k]` equals that flag and is not gated by any enable bit.
- R4: Flags are sticky. A flag stays 1 after its input falls. An input held high sets its flag only once, so after a clear the flag stays 0 until the input falls and rises again.
- R5: A write to the status register (address 0x0) clears every flag whose bit is 1 in the write data. Flags whose bit is 0 keep their value.
- R6: When a new edge event and a write-1 clear reach the same flag at the same clock edge, the flag ends up 1.
- R7: For n = 0 to 3, `irq_o[n]` is 1 exactly when external flag n and enable bit n are both 1.
- R8: `irq_o[4]` is 1 exactly when some n in 4 to 15 has both external flag n and enable bit n set.
- R9: Clearing an enable bit does not stop its flag from being set. It only removes that flag from `irq_o`.
- R10: Status register layout at address 0x0: bit 31 holds non-maskable flag 0, bit 30 holds non-maskable flag 1, and bit n holds external flag n for n = 0 to 15. Bits 29 to 16 read 0.
- R11: The enable register at address 0x4 holds enable bit n at bit n for n = 0 to 15, and its bits 31 to 16 read 0. Writes to it take effect at the next clock edge.
- R12: Reads return data in the same cycle as the address. Any address other than 0x0 and 0x4 reads 0, and writes to such an address change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_i | input | 16 | Asynchronous external interrupt request pins |
| nmi_i | input | 2 | Asynchronous non-maskable request pins, one per core |
| reg_addr | input | 4 | Register byte address |
| reg_wr | input | 1 | Write strobe, applied at the next clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| irq_o | output | 5 | Requests: bits 3..0 are dedicated to sources 0..3, bit 4 is shared by sources 4..15 |
| nmi_req_o | output | 2 | Non-maskable requests to core 0 and core 1 |

## Verification
Directed cases cover several patterns:
- A single rising edge is sampled edge by edge, which separates the correct three-edge latency from a short or missing synchronizer stage.
- A level held high across a clear shows whether the design detects edges or levels.
- An edge timed to the same cycle as a write-1 clear decides which of the two takes priority.
- Writes with mixed one and zero bits, and writes to unused addresses, show whether clears touch only the bits they should.

A long random phase then toggles all eighteen inputs sparsely and mixes in status, enable and stray writes. Against a cycle-accurate bench model, it exposes wrong bit placement and wrong grouping of sources 4 to 15 into the shared line. It also exposes any enable that blocks a flag from being set rather than only gating its request.

// File: rtl/eia_pkg.sv
package eia_pkg;
  localparam int unsigned NUM_EXT     = 16;
  localparam int unsigned NUM_NMI     = 2;
  localparam int unsigned NUM_DED     = 4;
  localparam int unsigned NUM_SRC     = NUM_EXT + NUM_NMI;
  localparam int unsigned NUM_IRQ     = NUM_DED + 1;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned ADDR_W      = 4;
  localparam int unsigned SYNC_STAGES = 2;

  localparam logic [ADDR_W-1:0] STATUS_OFF = 4'h0;
  localparam logic [ADDR_W-1:0] ENABLE_OFF = 4'h4;

  // Non-maskable flag k sits at bit NMI_TOP_BIT - k of the status word
  localparam int unsigned NMI_TOP_BIT = DATA_W - 1;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_ENABLE = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/eia_sync_edge.sv
module eia_sync_edge #(
  parameter int unsigned WIDTH  = 18,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= stage_q[STAGES-1];
  end

  assign rise_o = stage_q[STAGES-1] & ~last_q;

  // An edge event lasts one cycle, never two in a row (R4)
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/eia_flag_bank.sv
module eia_flag_bank #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] flag_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_o[i] <= 1'b0;
      else if (set_i[i]) flag_o[i] <= 1'b1;
      else if (clr_i[i]) flag_o[i] <= 1'b0;
    end
  end

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flag_o & $past(set_i)) == $past(set_i)));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((flag_o & $past(clr_i & ~set_i)) == '0));

  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_o & ~$past(flag_o) & ~$past(set_i)) == '0));
endmodule

// File: rtl/eia_req_combine.sv
module eia_req_combine #(
  parameter int unsigned NUM_EXT = 16,
  parameter int unsigned NUM_DED = 4
) (
  input  logic [NUM_EXT-1:0] flag_i,
  input  logic [NUM_EXT-1:0] en_i,
  output logic [NUM_DED:0]   irq_o
);
  logic [NUM_EXT-1:0] active;
  assign active = flag_i & en_i;

  for (genvar n = 0; n < NUM_DED; n++) begin : g_ded
    assign irq_o[n] = active[n];
  end

  assign irq_o[NUM_DED] = |active[NUM_EXT-1:NUM_DED];
endmodule

// File: rtl/eia_regif.sv
module eia_regif
  import eia_pkg::*;
#(
  parameter int unsigned N_EXT = NUM_EXT,
  parameter int unsigned N_NMI = NUM_NMI
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   wr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [N_EXT+N_NMI-1:0] flag_i,
  output logic [N_EXT+N_NMI-1:0] clr_o,
  output logic [N_EXT-1:0]       en_o,
  output logic [DATA_W-1:0]      rdata_o
);
  reg_sel_e sel;

  always_comb begin
    unique case (addr_i)
      STATUS_OFF: sel = SEL_STATUS;
      ENABLE_OFF: sel = SEL_ENABLE;
      default:    sel = SEL_NONE;
    endcase
  end

  // Enable register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         en_o <= '0;
    else if (wr_i && sel == SEL_ENABLE) en_o <= wdata_i[N_EXT-1:0];
  end

  // Status word view and write-one-to-clear decode
  logic [DATA_W-1:0] status_word;
  logic [DATA_W-1:0] enable_word;

  always_comb begin
    status_word = '0;
    status_word[N_EXT-1:0] = flag_i[N_EXT-1:0];
    for (int k = 0; k < N_NMI; k++)
      status_word[NMI_TOP_BIT-k] = flag_i[N_EXT+k];
    enable_word = '0;
    enable_word[N_EXT-1:0] = en_o;
  end

  always_comb begin
    clr_o = '0;
    if (wr_i && sel == SEL_STATUS) begin
      clr_o[N_EXT-1:0] = wdata_i[N_EXT-1:0];
      for (int k = 0; k < N_NMI; k++)
        clr_o[N_EXT+k] = wdata_i[NMI_TOP_BIT-k];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_STATUS: rdata_o = status_word;
      SEL_ENABLE: rdata_o = enable_word;
      default:    rdata_o = '0;
    endcase
  end

  // Writes to unused addresses leave the enable register alone (R12)
  p_stray_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel == SEL_NONE) |=> $stable(en_o));
endmodule

// File: rtl/ext_irq_aggregator.sv
module ext_irq_aggregator
  import eia_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_req_i,
  input  logic [NUM_NMI-1:0] nmi_i,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [NUM_IRQ-1:0] irq_o,
  output logic [NUM_NMI-1:0] nmi_req_o
);
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] clr;
  logic [NUM_SRC-1:0] flag;
  logic [NUM_EXT-1:0] en;

  eia_sync_edge #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({nmi_i, ext_req_i}),
    .rise_o  (rise)
  );

  eia_flag_bank #(.WIDTH(NUM_SRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (rise),
    .clr_i  (clr),
    .flag_o (flag)
  );

  eia_regif #(.N_EXT(NUM_EXT), .N_NMI(NUM_NMI)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (reg_addr),
    .wr_i    (reg_wr),
    .wdata_i (reg_wdata),
    .flag_i  (flag),
    .clr_o   (clr),
    .en_o    (en),
    .rdata_o (reg_rdata)
  );

  eia_req_combine #(.NUM_EXT(NUM_EXT), .NUM_DED(NUM_DED)) u_comb (
    .flag_i (flag[NUM_EXT-1:0]),
    .en_i   (en),
    .irq_o  (irq_o)
  );

  assign nmi_req_o = flag[NUM_SRC-1:NUM_EXT];

  // Writing an all-zero enable mask silences every maskable request (R7, R8)
  p_gate_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ENABLE_OFF && reg_wdata[NUM_EXT-1:0] == '0)
      |=> (irq_o == '0));
endmodule

// File: tb/ext_irq_aggregator_test.sv
module ext_irq_aggregator_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ext_req_i = '0;
  logic [1:0]  nmi_i = '0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [4:0]  irq_o;
  logic [1:0]  nmi_req_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Bench model: index 15..0 external, 16..17 non-maskable
  logic [17:0] m_d1 = '0, m_d2 = '0, m_d3 = '0, m_flag = '0;
  logic [15:0] m_en = '0;

  ext_irq_aggregator uut (
    .clk(clk), .rst_n(rst_n), .ext_req_i(ext_req_i), .nmi_i(nmi_i),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o), .nmi_req_o(nmi_req_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_status(logic [17:0] f);
    logic [31:0] w = '0;
    w[15:0] = f[15:0];
    w[31]   = f[16];
    w[30]   = f[17];
    return w;
  endfunction

  function automatic logic [4:0] exp_irq(logic [17:0] f, logic [15:0] e);
    logic [15:0] a = f[15:0] & e;
    return {|a[15:4], a[3:0]};
  endfunction

  function automatic logic [17:0] clr_vec(logic wr, logic [3:0] a, logic [31:0] d);
    logic [17:0] c = '0;
    if (wr && a == 4'h0) begin
      c[15:0] = d[15:0];
      c[16]   = d[31];
      c[17]   = d[30];
    end
    return c;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at the falling edge, update the model at the rising edge
  task automatic tick(input logic [15:0] ext, input logic [1:0] nmi,
                      input logic wr, input logic [3:0] a, input logic [31:0] d);
    logic [17:0] rise;
    @(negedge clk);
    ext_req_i = ext; nmi_i = nmi; reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    rise   = m_d2 & ~m_d3;
    m_flag = (m_flag & ~clr_vec(wr, a, d)) | rise;
    if (wr && a == 4'h4) m_en = d[15:0];
    m_d3 = m_d2; m_d2 = m_d1; m_d1 = {nmi, ext};
    #1;
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(ext_req_i, nmi_i, 1'b0, 4'h0, '0);
  endtask

  // Full comparison against the model, reads made between edges
  task automatic check_all(input string tag);
    reg_addr = 4'h0; #1;
    check(reg_rdata, exp_status(m_flag), {tag, " status R10"});
    reg_addr = 4'h4; #1;
    check(reg_rdata, {16'h0, m_en}, {tag, " enable R11"});
    check({27'h0, irq_o}, {27'h0, exp_irq(m_flag, m_en)}, {tag, " irq R7 R8"});
    check({30'h0, nmi_req_o}, {30'h0, m_flag[17:16]}, {tag, " nmi R3"});
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    reg_addr = 4'h0; #1; check(reg_rdata, 32'h0, "R1 status");
    reg_addr = 4'h4; #1; check(reg_rdata, 32'h0, "R1 enable");
    check({27'h0, irq_o}, 32'h0, "R1 irq");
    check({30'h0, nmi_req_o}, 32'h0, "R1 nmi");
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // R2: latency of a single edge on source 5
    tick(16'h0020, 2'b00, 1'b0, 4'h0, '0);
    reg_addr = 4'h0; #1; check({31'h0, reg_rdata[5]}, 32'h0, "R2 edge1");
    tick(16'h0020, 2'b00, 1'b0, 4'h0, '0);
    reg_addr = 4'h0; #1; check({31'h0, reg_rdata[5]}, 32'h0, "R2 edge2");
    tick(16'h0020, 2'b00, 1'b0, 4'h0, '0);
    reg_addr = 4'h0; #1; check(reg_rdata, 32'h0000_0020, "R2 edge3");
    // R9: enable off, flag still set, no request
    check({27'h0, irq_o}, 32'h0, "R9 no irq when disabled");

    // R4: input falls, flag sticks
    tick(16'h0000, 2'b00, 1'b0, 4'h0, '0); idle(4);
    reg_addr = 4'h0; #1; check(reg_rdata, 32'h0000_0020, "R4 sticky");

    // R5: write zero no effect, write one clears
    tick(16'h0, 2'b00, 1'b1, 4'h0, 32'hFFFF_FFDF); idle(1);
    reg_addr = 4'h0; #1; check(reg_rdata, 32'h0000_0020, "R5 write zero keeps");
    tick(16'h0, 2'b00, 1'b1, 4'h0, 32'h0000_0020);
    reg_addr = 4'h0; #1; check(reg_rdata, 32'h0, "R5 write one clears");

    // R4: level held high sets once only
    tick(16'h0001, 2'b00, 1'b0, 4'h0, '0); idle(4);
    tick(16'h0001, 2'b00, 1'b1, 4'h0, 32'h1); idle(4);
    reg_addr = 4'h0; #1; check(reg_rdata, 32'h0, "R4 held level no reset");

    // R3: non-maskable edges, no enable needed
    tick(16'h0001, 2'b11, 1'b0, 4'h0, '0); idle(3);
    reg_addr = 4'h0; #1; check(reg_rdata, 32'hC000_0000, "R3 R10 nmi bits");
    check({30'h0, nmi_req_o}, 32'h3, "R3 nmi direct");
    tick(16'h0001, 2'b11, 1'b1, 4'h0, 32'h8000_0000);
    check({30'h0, nmi_req_o}, 32'h2, "R3 R10 clear nmi0 only");

    // R6: set wins over clear in the same cycle (source 2)
    tick(16'h0004, 2'b11, 1'b0, 4'h0, '0); idle(3);
    tick(16'h0000, 2'b11, 1'b0, 4'h0, '0); idle(3);
    tick(16'h0004, 2'b11, 1'b0, 4'h0, '0);
    tick(16'h0004, 2'b11, 1'b0, 4'h0, '0);
    tick(16'h0004, 2'b11, 1'b1, 4'h0, 32'h0000_0004);
    reg_addr = 4'h0; #1; check({31'h0, reg_rdata[2]}, 32'h1, "R6 set wins");

    // R7, R8, R11: enable gating
    tick(16'h0004, 2'b11, 1'b1, 4'h4, 32'hFFFF_0004);
    reg_addr = 4'h4; #1; check(reg_rdata, 32'h0000_0004, "R11 enable layout");
    check({27'h0, irq_o}, 32'h04, "R7 dedicated line 2");
    tick(16'h1004, 2'b11, 1'b1, 4'h4, 32'h0000_1000); idle(3);
    check({27'h0, irq_o}, 32'h10, "R8 shared line");

    // R12: unused addresses read 0 and ignore writes
    tick(16'h1004, 2'b11, 1'b1, 4'h8, 32'hFFFF_FFFF);
    reg_addr = 4'h8; #1; check(reg_rdata, 32'h0, "R12 unused read");
    check_all("R12 after stray write");

    // Random phase
    for (int it = 0; it < 3000; it++) begin
      logic [15:0] e = ext_req_i ^ (16'($urandom()) & 16'($urandom()) & 16'($urandom()));
      logic [1:0]  n = nmi_i ^ (2'($urandom()) & 2'($urandom()) & 2'($urandom()));
      int          k = $urandom_range(0, 9);
      logic [3:0]  a = (k < 4) ? 4'h0 : (k < 7) ? 4'h4 : 4'($urandom());
      logic        w = (k < 8) && ($urandom_range(0, 2) == 0);
      tick(e, n, w, a, $urandom());
      check_all("random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule